// File: doc/BRIEF.md
# Pointer Tag Check Unit

This unit guards loads and stores with a memory-tagging rule. Every pointer carries a small colour in bits of its upper address that translation never uses, and every 16-byte granule of memory carries a colour of its own. For each access, the unit compares the two colours. If they match, the access is granted. If they differ, an exception response is returned instead. A pointer kept after its memory was freed and recoloured therefore fails its next access.

The allocation path recolours memory with a fill command. The command names a start address, a granule count and a colour, and the unit writes that colour into consecutive granules, one granule per cycle, holding a busy output while it works. Checks can be switched off, in which case every access is granted. The first exception is latched into fault status outputs: the address, the pointer colour and the stored colour. These stay frozen until software clears them.

Top module: `tagchk_unit`

## Requirements
- R1: After reset every stored granule colour is 0, and `set_busy`, `rsp_valid` and `flt_valid` are low.
- R2: The pointer colour is address bits 59:56. The granule index is address bits 9:4 (bits 3:0 are dropped and higher bits are ignored at the default depth of 64). With checks enabled, a request whose colour equals the stored colour gets `rsp_grant` high and `rsp_fault` low.
- R3: With checks enabled, a request whose colour differs from the stored colour gets `rsp_fault` high and `rsp_grant` low. This includes a stale pointer after its granules were recoloured.
- R4: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and in that cycle exactly one of `rsp_grant` and `rsp_fault` is high.
- R5: A fill is accepted when `set_valid` is high and `set_busy` is low. It writes `set_tag` into `set_count` consecutive granules starting at the granule of `set_addr`, one per cycle. `set_busy` is high for exactly `set_count` cycles starting the cycle after acceptance. A `set_valid` pulse while busy is ignored.
- R6: A fill with `set_count` equal to 0 writes nothing and leaves `set_busy` low.
- R7: Fill granule indices wrap from the last granule (63) back to granule 0.
- R8: With `chk_en` low during a request, the response is a grant, `rsp_fault` stays low and no fault is recorded.
- R9: The first fault loads `flt_addr`, `flt_ptr_tag` and `flt_mem_tag` and sets `flt_valid`. While `flt_valid` is high and no clear is given, later faults change none of these.
- R10: `flt_clr` drops `flt_valid`. A fault whose request is sampled in the same cycle as the clear is recorded instead.
- R11: A request sampled in the same cycle that a fill writes its granule sees the colour stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_en | input | 1 | Tag checking enabled when high |
| set_valid | input | 1 | Fill command strobe |
| set_addr | input | 64 | Address of first granule to recolour |
| set_count | input | 8 | Number of granules to recolour |
| set_tag | input | 4 | Colour to write |
| set_busy | output | 1 | Fill in progress |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 64 | Tagged pointer of the access |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Tag mismatch exception |
| flt_clr | input | 1 | Clear the recorded fault |
| flt_valid | output | 1 | A fault is recorded |
| flt_addr | output | 64 | Pointer of the recorded fault |
| flt_ptr_tag | output | 4 | Pointer colour of the recorded fault |
| flt_mem_tag | output | 4 | Stored colour of the recorded fault |

## Verification
A response and the fault status it may load both appear one clock edge after the request is sampled. The bench therefore queues the expected verdict when it drives a request, and the monitor pops it on the following falling edge; the fault outputs are read at that same falling edge. A fill's first write lands on the edge after acceptance, and busy is then counted on falling edges, where it must total exactly the requested granule count. The same-cycle write-versus-read case is staged by issuing the request on the second falling edge after the fill is accepted.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
   localparam int unsigned TAG_BITS = 4;
   typedef logic [TAG_BITS-1:0] mtag_t;
endpackage

// File: rtl/tagchk_store.sv
module tagchk_store
   import tagchk_pkg::*;
#(
   parameter int unsigned IDX_W = 6,
   localparam int unsigned DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  mtag_t            wr_tag,
   input  logic [IDX_W-1:0] rd_idx,
   output mtag_t            rd_tag
);
   logic [DEPTH*TAG_BITS-1:0] ent_flat;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      mtag_t ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ent_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(e)) ent_q <= wr_tag;
      end
      assign ent_flat[e*TAG_BITS +: TAG_BITS] = ent_q;
   end

   assign rd_tag = ent_flat[rd_idx*TAG_BITS +: TAG_BITS];
endmodule

// File: rtl/tagchk_fill.sv
module tagchk_fill
   import tagchk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_LOG2 = 4,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned CNT_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_valid,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [CNT_W-1:0]  set_count,
   input  mtag_t             set_tag,
   output logic              busy,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output mtag_t             wr_tag
);
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] left_q;
   mtag_t            tag_q;
   logic             accept;
   logic             unused_bits;

   assign busy   = (left_q != '0);
   assign accept = set_valid && !busy;
   assign unused_bits = ^{set_addr[ADDR_W-1:GRAN_LOG2+IDX_W], set_addr[GRAN_LOG2-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         left_q <= '0;
         tag_q  <= '0;
      end else if (accept) begin
         idx_q  <= set_addr[GRAN_LOG2 +: IDX_W];
         left_q <= set_count;
         tag_q  <= set_tag;
      end else if (busy) begin
         idx_q  <= idx_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   assign wr_en  = busy;
   assign wr_idx = idx_q;
   assign wr_tag = tag_q;

   assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_valid && !busy && set_count != '0) |=> busy);
   assert_zero_count_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_valid && !busy && set_count == '0) |=> !busy);
   assert_target_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(accept) && $past(busy)) |-> (wr_idx == $past(wr_idx) + 1'b1));
endmodule

// File: rtl/tagchk_check.sv
module tagchk_check
   import tagchk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_LOG2 = 4,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned TAG_LSB   = 56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [IDX_W-1:0]  rd_idx,
   input  mtag_t             mem_tag,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_fault,
   input  logic              flt_clr,
   output logic              flt_valid,
   output logic [ADDR_W-1:0] flt_addr,
   output mtag_t             flt_ptr_tag,
   output mtag_t             flt_mem_tag
);
   mtag_t ptr_tag;
   logic  fault_now;
   logic  capture;

   assign rd_idx    = req_addr[GRAN_LOG2 +: IDX_W];
   assign ptr_tag   = req_addr[TAG_LSB +: TAG_BITS];
   assign fault_now = req_valid && chk_en && (ptr_tag != mem_tag);
   assign capture   = fault_now && (!flt_valid || flt_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= req_valid && !fault_now;
         rsp_fault <= fault_now;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_valid   <= 1'b0;
         flt_addr    <= '0;
         flt_ptr_tag <= '0;
         flt_mem_tag <= '0;
      end else if (capture) begin
         flt_valid   <= 1'b1;
         flt_addr    <= req_addr;
         flt_ptr_tag <= ptr_tag;
         flt_mem_tag <= mem_tag;
      end else if (flt_clr) begin
         flt_valid   <= 1'b0;
      end
   end

   assert_rsp_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_stray_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_one_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_grant != rsp_fault));
   assert_disabled_grants_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !chk_en) |=> (rsp_grant && !rsp_fault));
   assert_fault_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !flt_clr) |=> (flt_valid && $stable(flt_addr) &&
                                   $stable(flt_ptr_tag) && $stable(flt_mem_tag)));
   assert_record_needs_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_valid) |-> rsp_fault);
   assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_clr && !req_valid) |=> !flt_valid);
endmodule

// File: rtl/tagchk_unit.sv
module tagchk_unit
   import tagchk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned GRAN_LOG2 = 4,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TAG_LSB   = 56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              set_valid,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [CNT_W-1:0]  set_count,
   input  logic [3:0]        set_tag,
   output logic              set_busy,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_fault,
   input  logic              flt_clr,
   output logic              flt_valid,
   output logic [ADDR_W-1:0] flt_addr,
   output logic [3:0]        flt_ptr_tag,
   output logic [3:0]        flt_mem_tag
);
   if (TAG_LSB + TAG_BITS > ADDR_W) begin : g_bad_tag_pos
      $error("tag field exceeds address width");
   end
   if (GRAN_LOG2 + IDX_W > TAG_LSB) begin : g_bad_index
      $error("granule index overlaps tag field");
   end
   if (CNT_W < 1) begin : g_bad_count
      $error("count width must be at least one");
   end

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   mtag_t            wr_tag;
   logic [IDX_W-1:0] rd_idx;
   mtag_t            rd_tag;

   tagchk_fill #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_addr(set_addr),
      .set_count(set_count), .set_tag(set_tag), .busy(set_busy),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag));

   tagchk_store #(.IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
      .rd_idx(rd_idx), .rd_tag(rd_tag));

   tagchk_check #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .IDX_W(IDX_W), .TAG_LSB(TAG_LSB)) u_check (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .req_valid(req_valid), .req_addr(req_addr),
      .rd_idx(rd_idx), .mem_tag(rd_tag), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
      .rsp_fault(rsp_fault), .flt_clr(flt_clr), .flt_valid(flt_valid), .flt_addr(flt_addr),
      .flt_ptr_tag(flt_ptr_tag), .flt_mem_tag(flt_mem_tag));
endmodule

// File: tb/tagchk_unit_tb_top.sv
module tagchk_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_en = 1'b1;
   logic        set_valid = 1'b0;
   logic [63:0] set_addr = '0;
   logic [7:0]  set_count = '0;
   logic [3:0]  set_tag = '0;
   logic        set_busy;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        rsp_valid, rsp_grant, rsp_fault;
   logic        flt_clr = 1'b0;
   logic        flt_valid;
   logic [63:0] flt_addr;
   logic [3:0]  flt_ptr_tag, flt_mem_tag;

   int checks = 0;
   int errors = 0;
   logic [3:0] model [64];
   logic       exp_q [$];

   always #4 clk = ~clk;

   tagchk_unit dut_i (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .set_valid(set_valid),
      .set_addr(set_addr), .set_count(set_count), .set_tag(set_tag), .set_busy(set_busy),
      .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .flt_clr(flt_clr),
      .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_ptr_tag(flt_ptr_tag),
      .flt_mem_tag(flt_mem_tag));

   function automatic logic [63:0] mk(input logic [3:0] tag, input int gran);
      return {4'h0, tag, 56'h0} | (64'(gran) << 4);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: one response due one edge after each request (R4)
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) chk("R4 unexpected response", 64'(rsp_valid), 64'h0);
         else begin
            logic f;
            f = exp_q.pop_front();
            chk("R2/R3/R4 verdict fault", 64'(rsp_fault), 64'(f));
            chk("R4 verdict grant", 64'(rsp_grant), 64'(!f));
         end
      end
   end

   task automatic req_exp(input logic [63:0] a, input logic en, input logic f);
      req_valid = 1'b1; req_addr = a; chk_en = en;
      exp_q.push_back(f);
      @(negedge clk);
      req_valid = 1'b0; chk_en = 1'b1;
   endtask

   task automatic req(input logic [63:0] a, input logic en);
      req_exp(a, en, en && (a[59:56] != model[int'(a[9:4])]));
   endtask

   task automatic fill(input int gran, input int cnt, input logic [3:0] tag, input string r);
      int n = 0;
      set_valid = 1'b1; set_addr = mk(4'h0, gran) | 64'h0000_0F00_0000_0009;
      set_count = 8'(cnt); set_tag = tag;
      @(negedge clk);
      set_valid = 1'b0;
      while (set_busy && n < 300) begin n++; @(negedge clk); end
      chk({r, " busy cycles"}, 64'(n), 64'(cnt));
      for (int i = 0; i < cnt; i++) model[(gran + i) % 64] = tag;
   endtask

   task automatic pulse_clr();
      flt_clr = 1'b1; @(negedge clk); flt_clr = 1'b0;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", 64'(set_busy), 0);
      chk("R1 rsp_valid", 64'(rsp_valid), 0);
      chk("R1 flt_valid", 64'(flt_valid), 0);
      req(mk(4'h0, 5), 1'b1);                 // R1 colour 0 granted
      // R5: fill granules 4..7 with colour A
      fill(4, 4, 4'hA, "R5");
      for (int g = 4; g < 8; g++) req(mk(4'hA, g), 1'b1);
      // R2: unrelated high bits and low offset bits ignored
      req(mk(4'hA, 6) | 64'h8000_0100_0000_000F, 1'b1);
      // R3/R9: mismatch at granule 8, fault recorded
      req(mk(4'hA, 8), 1'b1);
      chk("R9 flt_valid", 64'(flt_valid), 1);
      chk("R9 flt_addr", flt_addr, mk(4'hA, 8));
      chk("R9 flt_ptr_tag", 64'(flt_ptr_tag), 64'hA);
      chk("R9 flt_mem_tag", 64'(flt_mem_tag), 64'h0);
      // R9: second fault does not overwrite
      req(mk(4'h3, 20), 1'b1);
      chk("R9 held addr", flt_addr, mk(4'hA, 8));
      // R10: clear alone
      pulse_clr();
      chk("R10 cleared", 64'(flt_valid), 0);
      // R8: disabled checks grant and record nothing
      req(mk(4'h9, 4), 1'b0);
      chk("R8 no record", 64'(flt_valid), 0);
      // R3: recolour (free), stale pointer faults
      fill(4, 2, 4'h3, "R5 retag");
      req(mk(4'hA, 4), 1'b1);
      req(mk(4'h3, 5), 1'b1);
      // R10: clear together with a new fault records the new one
      flt_clr = 1'b1;
      req(mk(4'h6, 7), 1'b1);
      flt_clr = 1'b0;
      chk("R10 capture with clear", 64'(flt_valid), 1);
      chk("R10 new addr", flt_addr, mk(4'h6, 7));
      pulse_clr();
      // R6: zero count
      fill(12, 0, 4'hF, "R6");
      req(mk(4'h0, 12), 1'b1);
      // R7: wrap 62,63,0,1
      fill(62, 4, 4'h7, "R7");
      req(mk(4'h7, 0), 1'b1);
      req(mk(4'h7, 1), 1'b1);
      req(mk(4'h7, 63), 1'b1);
      req(mk(4'h0, 2), 1'b1);
      req(mk(4'h7, 0) | 64'h400, 1'b1);      // R2 index bits above 9:4 alias
      // R5: set while busy ignored
      set_valid = 1'b1; set_addr = mk(4'h0, 20); set_count = 8'd3; set_tag = 4'h5;
      @(negedge clk);
      set_addr = mk(4'h0, 30); set_count = 8'd2; set_tag = 4'h9;
      @(negedge clk);
      set_valid = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3; i++) model[20 + i] = 4'h5;
      chk("R5 idle after fill", 64'(set_busy), 0);
      req(mk(4'h0, 30), 1'b1);
      req(mk(4'h5, 22), 1'b1);
      pulse_clr();
      // R11: read in the write cycle sees the old colour
      set_valid = 1'b1; set_addr = mk(4'h0, 40); set_count = 8'd3; set_tag = 4'hC;
      @(negedge clk);
      set_valid = 1'b0;
      @(negedge clk);
      req_exp(mk(4'hC, 41), 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3; i++) model[40 + i] = 4'hC;
      req(mk(4'hC, 41), 1'b1);
      repeat (2) @(negedge clk);
      chk("R4 all responses seen", 64'(exp_q.size()), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule